// File: doc/BRIEF.md
# Selectable Window/Timeout Watchdog

This block supervises a host controller. It counts millisecond ticks and expects the host to clear it in time. One configuration bit picks between two kinds of supervision. In timeout operation, a clear at any point restarts the count. In window operation, the period is split into a closed first half and an open second half. A clear in the open half restarts the count, and a clear in the closed half is treated as a fault. In either operation, letting the period run out is also a fault. Each fault raises a one-cycle reset request, which the surrounding reset logic acts on.

The host writes a new selection bit and period code at any time. The block holds the written values as pending, and they take effect at the next clear. The counter runs only while the chip is in its normal or standby mode. In every other mode the counter is held at zero and the block stays quiet.

Top module: `wdog_top`

## Requirements
- R1: After reset the applied configuration is window operation with period code 0, `rstReq` is low and `phaseOpen` is low.
- R2: Period codes 0..3 select PERIOD0..PERIOD3 ticks (defaults 5, 45, 100, 350). If no clear arrives within that many ticks, `rstReq` is high in the cycle after the last tick is sampled, in both operations, and the count restarts from zero.
- R3: In window operation (`cfgWindow`=1), counts below floor(period/2) form the closed phase. A clear in the closed phase makes `rstReq` high in the next cycle and restarts the count.
- R4: In window operation, a clear at a count of floor(period/2) or more restarts the count and raises no request.
- R5: In timeout operation (`cfgWindow`=0), a clear at any count restarts the count and raises no request.
- R6: `phaseOpen` is high only while the block is active and either timeout operation is applied or the count is at least floor(period/2).
- R7: A configuration write is only stored. It is applied when the next clear is sampled, whether that clear is valid or not. The clear itself is judged against the configuration applied before it.
- R8: Modes are encoded as 0 sleep, 1 stop, 2 normal-request, 3 normal and 4 standby. Outside modes 3 and 4, the count is held at zero, ticks and clears are ignored, and no request is raised. On entry to mode 3 or 4 the count starts from zero.
- R9: When a clear and a tick are sampled in the same cycle, the clear wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Current chip mode (0 sleep, 1 stop, 2 normal-request, 3 normal, 4 standby) |
| msTick | input | 1 | One-cycle millisecond tick |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWindow | input | 1 | 1 = window operation, 0 = timeout operation |
| cfgPeriod | input | 2 | Period code |
| clrStrobe | input | 1 | Host access to the timing register (clear) |
| rstReq | output | 1 | Reset request, high for one cycle per fault |
| phaseOpen | output | 1 | High while a clear would be accepted |

## Verification
The hardest case to reach is a clear that lands exactly on the boundary between the closed and open halves. It must land there for every period code and for both operations. The count is not visible at the ports, so the bench first forces a known starting point: it writes the configuration and issues a clear, which applies the configuration and zeroes the count. It then feeds an exact number of ticks before the next clear. It sweeps that number from zero up to the full period, for every code and both operations, alternating between normal and standby modes. The bench computes the expected request and phase from floor(period/2).

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_SLEEP   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_STOP    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_NREQ    = 3'd2;
  localparam logic [MODE_W-1:0] MODE_NORMAL  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_STANDBY = 3'd4;

  localparam int CODE_W   = 2;
  localparam int NUM_CODE = 1 << CODE_W;

  typedef struct packed {
    logic holdZero;  // inactive: force count to zero
    logic restart;   // clear or expiry: count back to zero
    logic step;      // advance count by one tick
    logic loadCfg;   // move pending configuration into use
  } cntStrobe_t;

  typedef struct packed {
    logic             window;
    logic [CODE_W-1:0] code;
  } wdogCfg_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int unsigned PERIOD0 = 5,
  parameter int unsigned PERIOD1 = 45,
  parameter int unsigned PERIOD2 = 100,
  parameter int unsigned PERIOD3 = 350,
  parameter int unsigned CNT_W   = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  input  wdogCfg_t   pendCfg,
  output logic       closedPhase,
  output logic       lastCount,
  output logic       openStatus
);
  localparam int unsigned PERIODS [NUM_CODE] = '{PERIOD0, PERIOD1, PERIOD2, PERIOD3};

  logic [CNT_W-1:0] periodTab [NUM_CODE];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodSel;
  logic [CNT_W-1:0] halfSel;
  wdogCfg_t         actCfg;

  for (genvar i = 0; i < NUM_CODE; i++) begin : g_tab
    assign periodTab[i] = CNT_W'(PERIODS[i]);
  end

  assign periodSel = periodTab[actCfg.code];
  assign halfSel   = periodSel >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCfg <= '{window: 1'b1, code: '0};
    end else if (strobe.loadCfg) begin
      actCfg <= pendCfg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.holdZero || strobe.restart) begin
      cnt <= '0;
    end else if (strobe.step) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign closedPhase = actCfg.window && (cnt < halfSel);
  assign lastCount   = (cnt == periodSel - 1'b1);
  assign openStatus  = !strobe.holdZero && !closedPhase;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] mode,
  input  logic              msTick,
  input  logic              cfgWrEn,
  input  logic              cfgWindow,
  input  logic [CODE_W-1:0] cfgPeriod,
  input  logic              clrStrobe,
  input  logic              closedPhase,
  input  logic              lastCount,
  output cntStrobe_t        strobe,
  output wdogCfg_t          pendCfg,
  output logic              rstReq
);
  logic active;
  logic badClear;
  logic expire;

  assign active = (mode == MODE_NORMAL) || (mode == MODE_STANDBY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCfg <= '{window: 1'b1, code: '0};
    end else if (cfgWrEn) begin
      pendCfg <= '{window: cfgWindow, code: cfgPeriod};
    end
  end

  always_comb begin
    badClear        = active && clrStrobe && closedPhase;
    expire          = active && !clrStrobe && msTick && lastCount;
    strobe.holdZero = !active;
    strobe.loadCfg  = active && clrStrobe;
    strobe.restart  = active && (clrStrobe || (msTick && lastCount));
    strobe.step     = active && !clrStrobe && msTick && !lastCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReq <= 1'b0;
    else       rstReq <= badClear || expire;
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned PERIOD0 = 5,
  parameter int unsigned PERIOD1 = 45,
  parameter int unsigned PERIOD2 = 100,
  parameter int unsigned PERIOD3 = 350
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] mode,
  input  logic       msTick,
  input  logic       cfgWrEn,
  input  logic       cfgWindow,
  input  logic [1:0] cfgPeriod,
  input  logic       clrStrobe,
  output logic       rstReq,
  output logic       phaseOpen
);
  localparam int unsigned MAX01  = (PERIOD0 > PERIOD1) ? PERIOD0 : PERIOD1;
  localparam int unsigned MAX23  = (PERIOD2 > PERIOD3) ? PERIOD2 : PERIOD3;
  localparam int unsigned MAXP   = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W  = $clog2(MAXP + 1);

  cntStrobe_t strobe;
  wdogCfg_t   pendCfg;
  logic       closedPhase;
  logic       lastCount;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .msTick(msTick),
    .cfgWrEn(cfgWrEn), .cfgWindow(cfgWindow), .cfgPeriod(cfgPeriod),
    .clrStrobe(clrStrobe), .closedPhase(closedPhase), .lastCount(lastCount),
    .strobe(strobe), .pendCfg(pendCfg), .rstReq(rstReq)
  );

  wdog_dp #(
    .PERIOD0(PERIOD0), .PERIOD1(PERIOD1), .PERIOD2(PERIOD2), .PERIOD3(PERIOD3),
    .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pendCfg(pendCfg),
    .closedPhase(closedPhase), .lastCount(lastCount), .openStatus(phaseOpen)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] mode,
  input logic       clrStrobe,
  input logic       rstReq,
  input logic       phaseOpen
);
  logic active;
  assign active = (mode == 3'd3) || (mode == 3'd4);

  p_quiet_inactive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !rstReq);

  p_phase_inactive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !phaseOpen);

  p_closed_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (active && clrStrobe && !phaseOpen) |=> rstReq);

  p_open_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && clrStrobe && phaseOpen) |=> !rstReq);

  p_req_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(active));
endmodule

bind wdog_top wdog_checker u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .clrStrobe(clrStrobe),
  .rstReq(rstReq), .phaseOpen(phaseOpen)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
  localparam int P [4] = '{4, 6, 8, 10};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] mode = 3'd0;
  logic msTick = 1'b0, cfgWrEn = 1'b0, cfgWindow = 1'b0, clrStrobe = 1'b0;
  logic [1:0] cfgPeriod = 2'd0;
  logic rstReq, phaseOpen;
  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_top #(.PERIOD0(4), .PERIOD1(6), .PERIOD2(8), .PERIOD3(10)) u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .msTick(msTick), .cfgWrEn(cfgWrEn),
    .cfgWindow(cfgWindow), .cfgPeriod(cfgPeriod), .clrStrobe(clrStrobe),
    .rstReq(rstReq), .phaseOpen(phaseOpen)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input logic cl);
    msTick = tk; clrStrobe = cl;
    @(negedge clk);
    msTick = 1'b0; clrStrobe = 1'b0;
  endtask

  task automatic writeCfg(input logic w, input logic [1:0] c);
    cfgWrEn = 1'b1; cfgWindow = w; cfgPeriod = c;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic anyReq;
    repeat (3) @(negedge clk);
    check("R1 reset rstReq", rstReq, 1'b0);
    check("R1 reset phaseOpen", phaseOpen, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R8: inactive modes hold count and ignore ticks/clears
    for (int m = 0; m < 3; m++) begin
      mode = 3'(m);
      anyReq = 1'b0;
      for (int i = 0; i < 12; i++) begin
        cyc(1'b1, (i % 3) == 0);
        anyReq |= rstReq | phaseOpen;
      end
      check("R8 inactive quiet", anyReq, 1'b0);
    end
    // R1 default window, code 0: clear at count 0 is closed
    mode = 3'd3;
    @(negedge clk);
    check("R1 default closed phase", phaseOpen, 1'b0);
    cyc(1'b0, 1'b1);
    check("R1 default window clear", rstReq, 1'b1);
    @(negedge clk);
    check("R2 pulse drops", rstReq, 1'b0);
    // R8: count from zero after entry, expiry at P0
    mode = 3'd0; ticks(3); mode = 3'd4;
    ticks(P[0] - 1);
    check("R8 entry from zero", rstReq, 1'b0);
    ticks(1);
    check("R2 expiry default", rstReq, 1'b1);
    // R7: write stored only, applied at clear
    writeCfg(1'b0, 2'd3);
    ticks(P[0]);
    check("R7 old period still applies", rstReq, 1'b1);
    cyc(1'b0, 1'b1);
    check("R7 clear judged on old config", rstReq, 1'b1);
    ticks(P[3] - 1);
    check("R7 new timeout open", phaseOpen, 1'b1);
    check("R7 new period no early req", rstReq, 1'b0);
    ticks(1);
    check("R7 new period expiry", rstReq, 1'b1);
    // R9: clear beats tick
    writeCfg(1'b0, 2'd0);
    cyc(1'b0, 1'b1);
    ticks(P[0] - 1);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);
    ticks(P[0] - 1);
    check("R9 tick not counted", rstReq, 1'b0);
    ticks(1);
    check("R9 expiry after restart", rstReq, 1'b1);
    // Sweep: R2..R6
    for (int w = 0; w < 2; w++) begin
      for (int c = 0; c < 4; c++) begin
        for (int k = 0; k <= P[c]; k++) begin
          mode = (c % 2) ? 3'd4 : 3'd3;
          writeCfg(w[0], 2'(c));
          cyc(1'b0, 1'b1);
          @(negedge clk);
          anyReq = 1'b0;
          for (int i = 0; i < k; i++) begin
            if (i == k - 1 && k == P[c]) begin
              cyc(1'b1, 1'b0);
            end else begin
              cyc(1'b1, 1'b0);
              anyReq |= rstReq;
            end
          end
          if (k == P[c]) begin
            check("R2 expiry sweep", rstReq, 1'b1);
            check("R2 no early req", anyReq, 1'b0);
          end else begin
            check("R6 phase sweep", phaseOpen, (w == 0) || (k >= P[c] / 2));
            cyc(1'b0, 1'b1);
            if (w == 1) check((k < P[c] / 2) ? "R3 closed clear" : "R4 open clear",
                              rstReq, k < P[c] / 2);
            else check("R5 timeout clear", rstReq, 1'b0);
          end
          @(negedge clk);
        end
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule